// File: doc/BRIEF.md
# Interrupt Controller Host Register Front End

This block is the host-side register port and setup sequencer of an eight-level interrupt controller. A host reaches it through one address line, a chip select, separate read and write strobes and byte-wide data in each direction. Only two addresses exist. Which internal register a given access reaches depends on three things: the address, how far the setup word sequence has progressed, and whether a poll has been armed.

Inside, the block keeps a pending-request register, an in-service register and a mask register. Priority is fixed, with level 0 highest. A host that does not use acknowledge cycles arms a poll and then reads one byte. That byte says whether an unmasked request is waiting and, if one is, which level. The same read moves that level from pending to in-service. An end-of-service command later clears the highest-priority in-service bit. A system with a primary and a secondary controller uses two independent instances of this block, and the two may be set up in either order.

Top module: `pic_host_front`

## Requirements
- R1: After reset the block is not set up. Pending, in-service and mask registers read 0, even-address reads return the pending register, and odd-address writes plus all command writes other than the first setup word are ignored.
- R2: A write at the even address (addrSel=0) with data bit 4 set is the first setup word, accepted at any time. It clears the mask and in-service registers, disarms poll, returns even-address reads to the pending register and restarts the sequence. Pending requests are kept.
- R3: After the first setup word, the next three writes at the odd address are taken as setup words two, three and four, in that order, and do not touch the mask. Even-address writes with bit 4 clear are ignored until word four has been written, after which the block is set up.
- R4: A request input that is high at a clock edge sets its bit in the pending register. The bit stays set after the input drops, until a poll read grants that level.
- R5: Once set up, and with poll not armed, a write at the odd address loads the mask register and a read at the odd address returns it.
- R6: Once set up, an even-address write with bit 4 clear and bit 3 set is a read-control command. If its bit 1 is 1, its bit 0 selects what even-address reads return: 0 for the pending register, 1 for the in-service register. If its bit 1 is 0, the selection is left unchanged.
- R7: A read-control command with bit 2 set arms poll. The next read at either address returns the poll byte and disarms poll. If an unmasked request is pending, the poll byte has bit 7 set and bits 2:0 holding the lowest-numbered such level. If none is pending, the poll byte is 0x00.
- R8: A poll read that reports a level sets that in-service bit and clears that pending bit. When the request input of that level is high in the same cycle, the clear wins, and the bit is set again only at a later edge.
- R9: Once set up, an even-address write with bits 4 and 3 clear and bits 7:5 equal to 001 clears the lowest-numbered set in-service bit. Any other value in bits 7:5 leaves the in-service register unchanged.
- R10: Masked requests remain visible in the pending register, but a poll neither reports them nor grants them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Host access select, active high |
| rdStb | input | 1 | Read strobe, one cycle per read |
| wrStb | input | 1 | Write strobe, one cycle per write |
| addrSel | input | 1 | Host address bit: 0 even, 1 odd |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, combinational from address and state |
| irqIn | input | 8 | Request inputs, one per level |

## Verification
Two functions can fall in the same cycle: a request input latching a level and a poll read granting that same level. The bench holds one request input high across the cycle of the poll read. It then reads the pending register back. The bit must be found clear if the input dropped right after the read, and set again if the input stayed high one cycle longer. Exhaustive sweeps over all 256 request patterns also place each poll grant next to mask and end-of-service updates. Each poll byte and each register read is compared against a lowest-set-bit model computed in the bench.

// File: rtl/pic_host_pkg.sv
package pic_host_pkg;

  localparam int DATA_W = 8;

  // Strobes and levels passed from the control module to the datapath
  typedef struct packed {
    logic clearRegs;  // first setup word seen this cycle
    logic loadMask;   // odd write while set up
    logic eoi;        // non-specific end of service
    logic pollAck;    // read while poll is armed
    logic selIsr;     // even reads return in-service register
    logic pollMode;   // poll armed: reads return the poll byte
    logic ready;      // setup sequence complete
  } hostStrobes_t;

  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_WORD2,
    ST_WORD3,
    ST_WORD4,
    ST_READY
  } seqState_t;

endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_IRQ-1:0] vecIn,
  output logic               anySet,
  output logic [LVL_W-1:0]   lowIdx
);

  // Lowest-numbered set bit wins (level 0 is highest priority)
  always_comb begin
    anySet = |vecIn;
    lowIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vecIn[i]) lowIdx = LVL_W'(i);
    end
  end

endmodule

// File: rtl/pic_host_ctrl.sv
module pic_host_ctrl
  import pic_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  output hostStrobes_t      cmd
);

  seqState_t seqQ, seqNext;
  logic selIsrQ, pollQ;

  logic wrAcc, rdAcc, firstWord, oddWr, evenCmd, isReady;
  logic readCtl, endSvc;

  assign wrAcc     = chipSel & wrStb;
  assign rdAcc     = chipSel & rdStb;
  assign firstWord = wrAcc & ~addrSel & wrData[4];
  assign oddWr     = wrAcc & addrSel;
  assign evenCmd   = wrAcc & ~addrSel & ~wrData[4];
  assign isReady   = (seqQ == ST_READY);
  assign readCtl   = isReady & evenCmd & wrData[3];
  assign endSvc    = isReady & evenCmd & ~wrData[3] & (wrData[7:5] == 3'b001);

  always_comb begin
    seqNext = seqQ;
    if (firstWord) begin
      seqNext = ST_WORD2;
    end else begin
      unique case (seqQ)
        ST_WORD2: if (oddWr) seqNext = ST_WORD3;
        ST_WORD3: if (oddWr) seqNext = ST_WORD4;
        ST_WORD4: if (oddWr) seqNext = ST_READY;
        default:  seqNext = seqQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ    <= ST_UNINIT;
      selIsrQ <= 1'b0;
      pollQ   <= 1'b0;
    end else begin
      seqQ <= seqNext;
      if (firstWord) begin
        selIsrQ <= 1'b0;
      end else if (readCtl && wrData[1]) begin
        selIsrQ <= wrData[0];
      end
      if (firstWord) begin
        pollQ <= 1'b0;
      end else if (rdAcc && pollQ) begin
        pollQ <= 1'b0;
      end else if (readCtl && wrData[2]) begin
        pollQ <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd.clearRegs = firstWord;
    cmd.loadMask  = isReady & oddWr;
    cmd.eoi       = endSvc;
    cmd.pollAck   = rdAcc & pollQ;
    cmd.selIsr    = selIsrQ;
    cmd.pollMode  = pollQ;
    cmd.ready     = isReady;
  end

endmodule

// File: rtl/pic_host_dp.sv
module pic_host_dp
  import pic_host_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  hostStrobes_t       cmd,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_IRQ-1:0] irrQ,
  output logic [NUM_IRQ-1:0] isrQ,
  output logic [NUM_IRQ-1:0] imrQ
);

  logic [NUM_IRQ-1:0] pending, grantOh, eoiOh;
  logic               pollHit, svcAny;
  logic [LVL_W-1:0]   pollLvl, svcLvl;
  logic [DATA_W-1:0]  pollByte;

  // Requests are only offered to poll once setup is complete
  assign pending = irrQ & ~imrQ & {NUM_IRQ{cmd.ready}};

  pic_prio_enc #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_pollEnc (
    .vecIn (pending),
    .anySet(pollHit),
    .lowIdx(pollLvl)
  );

  pic_prio_enc #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_svcEnc (
    .vecIn (isrQ),
    .anySet(svcAny),
    .lowIdx(svcLvl)
  );

  always_comb begin
    grantOh = '0;
    eoiOh   = '0;
    if (pollHit) grantOh[pollLvl] = 1'b1;
    if (svcAny)  eoiOh[svcLvl]    = 1'b1;
  end

  always_comb begin
    pollByte    = '0;
    pollByte[7] = pollHit;
    if (pollHit) pollByte[LVL_W-1:0] = pollLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      imrQ <= '0;
    end else begin
      // grant clear takes precedence over a same-cycle request
      irrQ <= (irrQ | irqIn) & ~(cmd.pollAck ? grantOh : '0);
      if (cmd.clearRegs) begin
        isrQ <= '0;
      end else if (cmd.pollAck) begin
        isrQ <= isrQ | grantOh;
      end else if (cmd.eoi) begin
        isrQ <= isrQ & ~eoiOh;
      end
      if (cmd.clearRegs) begin
        imrQ <= '0;
      end else if (cmd.loadMask) begin
        imrQ <= wrData[NUM_IRQ-1:0];
      end
    end
  end

  always_comb begin
    if (cmd.pollMode)    rdData = pollByte;
    else if (addrSel)    rdData = DATA_W'(imrQ);
    else if (cmd.selIsr) rdData = DATA_W'(isrQ);
    else                 rdData = DATA_W'(irrQ);
  end

endmodule

// File: rtl/pic_host_front.sv
module pic_host_front
  import pic_host_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipSel,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic               addrSel,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  input  logic [NUM_IRQ-1:0] irqIn
);

  localparam int LVL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  hostStrobes_t       cmd;
  logic [NUM_IRQ-1:0] irrQ, isrQ, imrQ;

  pic_host_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .chipSel(chipSel),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .addrSel(addrSel),
    .wrData (wrData),
    .cmd    (cmd)
  );

  pic_host_dp #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .addrSel(addrSel),
    .wrData (wrData),
    .irqIn  (irqIn),
    .cmd    (cmd),
    .rdData (rdData),
    .irrQ   (irrQ),
    .isrQ   (isrQ),
    .imrQ   (imrQ)
  );

endmodule

// File: rtl/pic_host_front_chk.sv
module pic_host_front_chk
  import pic_host_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               chipSel,
  input logic               rdStb,
  input logic               wrStb,
  input logic               addrSel,
  input logic [7:0]         wrData,
  input logic [7:0]         rdData,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic [NUM_IRQ-1:0] irrQ,
  input logic [NUM_IRQ-1:0] isrQ,
  input logic [NUM_IRQ-1:0] imrQ,
  input hostStrobes_t       cmd
);

  logic firstWr, pollRd;
  assign firstWr = chipSel && wrStb && !addrSel && wrData[4];
  assign pollRd  = chipSel && rdStb && cmd.pollMode;

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    firstWr |=> (imrQ == '0 && isrQ == '0 && !cmd.ready && !cmd.pollMode));

  assert_init_keeps_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.ready && !firstWr) |=> $stable(imrQ));

  assert_req_latched_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn != '0 && !cmd.pollAck) |=> ((irrQ & $past(irqIn)) == $past(irqIn)));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && wrStb && addrSel && cmd.ready) |=> (imrQ == $past(wrData[NUM_IRQ-1:0])));

  assert_poll_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollRd |=> !cmd.pollMode);

  assert_grant_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pollRd && rdData[7]) |=>
      (isrQ[$past(rdData[LVL_W-1:0])] && !irrQ[$past(rdData[LVL_W-1:0])]));

  assert_eoi_one_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.eoi && isrQ != '0) |=> ($countones(isrQ) == $countones($past(isrQ)) - 1));

  assert_masked_not_polled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pollRd && rdData[7]) |-> !imrQ[rdData[LVL_W-1:0]]);

endmodule

bind pic_host_front pic_host_front_chk #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .chipSel(chipSel),
  .rdStb  (rdStb),
  .wrStb  (wrStb),
  .addrSel(addrSel),
  .wrData (wrData),
  .rdData (rdData),
  .irqIn  (irqIn),
  .irrQ   (irrQ),
  .isrQ   (isrQ),
  .imrQ   (imrQ),
  .cmd    (cmd)
);

// File: tb/pic_host_front_tb.sv
module pic_host_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic       addrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] irqIn = 8'h00;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  pic_host_front u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .chipSel(chipSel),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .addrSel(addrSel),
    .wrData (wrData),
    .rdData (rdData),
    .irqIn  (irqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; wrStb = 1'b1; addrSel = a; wrData = d;
    @(negedge clk);
    chipSel = 1'b0; wrStb = 1'b0; wrData = 8'h00;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; rdStb = 1'b1; addrSel = a;
    #1 d = rdData;
    @(negedge clk);
    chipSel = 1'b0; rdStb = 1'b0;
  endtask

  task automatic setupWords();
    wrReg(1'b0, 8'h13);
    wrReg(1'b1, 8'h20);
    wrReg(1'b1, 8'h00);
    wrReg(1'b1, 8'h01);
  endtask

  task automatic pulseReq(input logic [7:0] p);
    @(negedge clk); irqIn = p;
    @(negedge clk); irqIn = 8'h00;
  endtask

  function automatic int lowBit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] pollExp(input logic [7:0] v);
    int l = lowBit(v);
    return (l < 0) ? 8'h00 : (8'h80 | 8'(l));
  endfunction

  function automatic logic [7:0] dropLow(input logic [7:0] v);
    return v & (v - 8'h01);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] d, m, rem, isrExp, rot;
    int guard;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, odd write ignored before setup
    rdReg(1'b0, d); check("R1 pending after reset", d, 8'h00);
    rdReg(1'b1, d); check("R1 mask after reset", d, 8'h00);
    wrReg(1'b1, 8'h55);
    rdReg(1'b1, d); check("R1 odd write ignored", d, 8'h00);
    pulseReq(8'h08);
    wrReg(1'b0, 8'h0C);  // poll command ignored before setup
    rdReg(1'b0, d); check("R1 poll ignored, R4 latch", d, 8'h08);

    // R3: setup sequence with a stray command in the middle
    wrReg(1'b0, 8'h13);
    wrReg(1'b1, 8'hFF);
    wrReg(1'b0, 8'h0B);  // ignored during setup
    rdReg(1'b1, d); check("R3 mask untouched by word two", d, 8'h00);
    wrReg(1'b1, 8'hFF);
    wrReg(1'b1, 8'hFF);
    rdReg(1'b1, d); check("R3 mask untouched by words", d, 8'h00);
    rdReg(1'b0, d); check("R3 read select unchanged", d, 8'h08);
    wrReg(1'b1, 8'hF0);
    rdReg(1'b1, d); check("R3 first odd write after setup is mask", d, 8'hF0);
    wrReg(1'b1, 8'h00);
    wrReg(1'b0, 8'h0C);
    rdReg(1'b1, d); check("R7 poll at odd address", d, 8'h83);
    rdReg(1'b0, d); check("R7 poll disarmed after one read", d, 8'h00);

    // R2: restart mid-operation
    pulseReq(8'h21);
    wrReg(1'b1, 8'hAA);
    wrReg(1'b0, 8'h0C);
    rdReg(1'b0, d); check("R2 pre poll", d, 8'h80);
    wrReg(1'b0, 8'h0B);
    wrReg(1'b0, 8'h0C);  // poll armed, then restart
    wrReg(1'b0, 8'h13);
    rdReg(1'b1, d); check("R2 mask cleared", d, 8'h00);
    wrReg(1'b1, 8'h00); wrReg(1'b1, 8'h00); wrReg(1'b1, 8'h01);
    rdReg(1'b0, d); check("R2 select back to pending, poll off", d, 8'h20);
    wrReg(1'b0, 8'h0B);
    rdReg(1'b0, d); check("R2 in-service cleared", d, 8'h00);
    wrReg(1'b0, 8'h0A);
    wrReg(1'b0, 8'h0C);
    rdReg(1'b0, d); check("R7 drain level 5", d, 8'h85);

    // R8: same-cycle request and grant on level 2
    wrReg(1'b0, 8'h13); setupWords();
    wrReg(1'b0, 8'h0C);
    @(negedge clk); irqIn = 8'h04;
    @(negedge clk);
    chipSel = 1'b1; rdStb = 1'b1; addrSel = 1'b0;
    #1 d = rdData;
    @(negedge clk);
    chipSel = 1'b0; rdStb = 1'b0; irqIn = 8'h00;
    check("R8 poll byte level 2", d, 8'h82);
    rdReg(1'b0, d); check("R8 clear wins over same-cycle request", d, 8'h00);
    wrReg(1'b0, 8'h0C);
    @(negedge clk); irqIn = 8'h04;
    @(negedge clk);
    chipSel = 1'b1; rdStb = 1'b1; addrSel = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    chipSel = 1'b0; rdStb = 1'b0;
    @(negedge clk); irqIn = 8'h00;
    check("R8 second grant", d, 8'h82);
    rdReg(1'b0, d); check("R8 later edge sets again", d, 8'h04);
    wrReg(1'b0, 8'h0C);
    rdReg(1'b0, d); check("R8 drain", d, 8'h82);

    // Exhaustive sweep over request patterns
    for (int p = 0; p < 256; p++) begin
      rot = 8'(p);
      m = {rot[3:0], rot[7:4]} ^ 8'h5A;
      wrReg(1'b0, 8'h13); setupWords();
      wrReg(1'b1, m);
      rdReg(1'b1, d); check("R5 mask readback", d, m);
      pulseReq(8'(p));
      rdReg(1'b0, d); check("R4 R10 pending shows all", d, 8'(p));
      rem = 8'(p) & ~m;
      guard = 0;
      do begin
        wrReg(1'b0, 8'h0C);
        rdReg(guard[0], d); check("R7 poll byte", d, pollExp(rem));
        rem = dropLow(rem);
        guard++;
      end while (d[7] && guard < 10);
      rdReg(1'b0, d); check("R10 masked stay pending", d, 8'(p) & m);
      wrReg(1'b0, 8'h0B);
      isrExp = 8'(p) & ~m;
      rdReg(1'b0, d); check("R6 R8 in-service view", d, isrExp);
      wrReg(1'b0, 8'h09);  // bit1 clear: selection kept
      rdReg(1'b0, d); check("R6 selection kept", d, isrExp);
      wrReg(1'b0, 8'h60);
      wrReg(1'b0, 8'h40);
      rdReg(1'b0, d); check("R9 other codes ignored", d, isrExp);
      while (isrExp != 8'h00) begin
        wrReg(1'b0, 8'h20);
        isrExp = dropLow(isrExp);
        rdReg(1'b0, d); check("R9 end of service", d, isrExp);
      end
      wrReg(1'b0, 8'h0A);
      wrReg(1'b1, 8'h00);
      rem = 8'(p) & m;
      guard = 0;
      do begin
        wrReg(1'b0, 8'h0C);
        rdReg(1'b0, d); check("R7 drain after unmask", d, pollExp(rem));
        rem = dropLow(rem);
        guard++;
      end while (d[7] && guard < 10);
    end

    finishRun();
  end

endmodule